// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Arbiter and Vector Generator

This block merges the interrupt sources of two serial channels into one interrupt request line. The sources are a received character, a transmit buffer load and a break condition. For each channel it keeps a receive pending flag, a receive in-service flag, a transmit pending flag and a transmit in-service flag. It also keeps a sticky break status. From these it drives a pending-bits register and a modified interrupt vector. The vector names the source that most recently entered service, or it holds a "no interrupt" code.

The host uses the block as follows. It feeds in one-cycle event strobes: character received, data port write, data port read, break seen, clear-transmit-interrupt command and reset-highest-in-service command. It also supplies the enable fields from its channel configuration. It then reads back the pending register and the vector to decide which service routine to run. A receive interrupt that is in service holds back a transmit interrupt of the same channel. That transmit interrupt stays pending and enters service once the receive in-service flag is cleared.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset, the pending register is 0x00, the vector is 0x00, the interrupt request is low and both break status flags are clear.
- R2: A received-character strobe sets that channel's receive pending and in-service flags on the same clock edge. It also sets pending bit 5 (channel A, index 0) or bit 2 (channel B, index 1), and writes the receive code into the vector.
- R3: A pending receive interrupt raises the request only when the channel's 2-bit receive mode is 01 or 10. Modes 00 and 11 never raise it. The request is registered, so it follows the flags one clock edge later.
- R4: A data port write with no receive interrupt in service puts the transmit interrupt into service and writes the transmit code into the vector. When the channel's transmit enable is set, it also sets pending bit 4 (A) or bit 1 (B). The request is raised while the enable is set and the transmit interrupt is pending.
- R5: A data port write while the channel's receive interrupt is in service leaves the transmit interrupt pending only. The transmit pending bit and the vector are unchanged, but the request is still raised when transmit enable is set.
- R6: A data port read clears the channel's receive pending and in-service flags and its receive pending bit, and sets the vector to the no-interrupt code. If a transmit interrupt is pending, that transmit interrupt then re-enters service as in R4.
- R7: Reset-highest-in-service clears the receive in-service flag if it is set. A pending transmit interrupt then enters service as in R4. If the receive in-service flag is not set, the command clears transmit in-service and leaves the pending register and the vector unchanged.
- R8: Clear-transmit-interrupt clears the channel's transmit flags and transmit pending bit and sets the vector to the no-interrupt code. If a receive interrupt is pending, the receive interrupt is then re-asserted as in R2.
- R9: A break strobe sets a sticky break status that only reset clears. The break status raises the request only while that channel's break enable is set.
- R10: With status-low selected (status_hi_i = 0), the codes are: A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00, no interrupt 0x06. With status-high selected, the same codes are 0x30, 0x20, 0x10, 0x00 and 0x60.
- R11: Events that arrive in the same cycle are applied in a fixed order. Within a channel the order is read, clear-transmit, reset-in-service, received character, then data write. Across channels, channel A is applied first and then channel B, so a vector write by channel B overrides one by channel A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_char_i | input | NUM_CH | Character received strobe, bit 0 = A |
| tx_load_i | input | NUM_CH | Data port write strobe |
| rd_data_i | input | NUM_CH | Data port read strobe |
| clr_tx_i | input | NUM_CH | Clear-transmit-interrupt command strobe |
| rst_ius_i | input | NUM_CH | Reset-highest-in-service command strobe |
| brk_det_i | input | NUM_CH | Break detected strobe |
| tx_ie_i | input | NUM_CH | Transmit interrupt enable per channel |
| rx_mode_i | input | 2*NUM_CH | Receive interrupt mode, bits [1:0] = A, [3:2] = B |
| brk_ie_i | input | NUM_CH | Break interrupt enable per channel |
| status_hi_i | input | 1 | Selects status-high vector encoding |
| irq_o | output | 1 | Registered interrupt request |
| pend_o | output | PEND_W | Pending-bits register |
| vec_o | output | VEC_W | Modified interrupt vector |

## Verification
The main sequence of the bench steps receive, transmit, read and command events through both channels. Each step is followed by a check of the pending register, the vector and the request. Patterns in which a transmit load arrives while a receive interrupt is in service show whether blocking and later promotion (by read or by reset-in-service) follow the right order, not simply last-event-wins. All four receive modes and both states of the transmit enable are exercised, which separates the pending bits from the request. Same-cycle events within one channel and across both channels pin down the fixed application order. The status-high runs confirm that the encoding is bit-reversed, not just shifted. A directed test samples the request between the two edges to confirm the one-cycle registration. A mid-run reset confirms that break status does not survive a reset.

// File: rtl/sivec_pkg.sv
package sivec_pkg;

   // kind of code last written into the vector register
   typedef enum logic [1:0] {
      VK_NONE = 2'd0,
      VK_RX   = 2'd1,
      VK_TX   = 2'd2
   } vkind_e;

   // per-channel interrupt state kept in flops
   typedef struct packed {
      logic rxp;   // receive interrupt pending
      logic rxs;   // receive interrupt in service
      logic txp;   // transmit interrupt pending
      logic txs;   // transmit interrupt in service
      logic rxb;   // receive bit of the pending register
      logic txb;   // transmit bit of the pending register
   } chst_t;

   // working value threaded through one cycle's events
   typedef struct packed {
      chst_t  st;
      logic   wr;    // this channel wrote the vector this cycle
      vkind_e kind;  // what it wrote
   } cwork_t;

   // pending-register bit positions, channel index 0 = A
   function automatic int rx_pend_pos(int ch);
      return 5 - 3 * ch;
   endfunction

   function automatic int tx_pend_pos(int ch);
      return 4 - 3 * ch;
   endfunction

   // three-bit code in status-low order
   function automatic logic [2:0] vcode3(vkind_e k, logic is_b);
      logic [2:0] c;
      case (k)
         VK_RX:   c = is_b ? 3'b010 : 3'b110;
         VK_TX:   c = is_b ? 3'b000 : 3'b100;
         default: c = 3'b011;
      endcase
      return c;
   endfunction

   // status-low puts the code at [3:1]; status-high puts it bit-reversed at [6:4]
   function automatic logic [7:0] vec_value(vkind_e k, logic is_b, logic hi);
      logic [2:0] c;
      c = vcode3(k, is_b);
      if (hi)
         return {1'b0, c[0], c[1], c[2], 4'b0000};
      else
         return {4'b0000, c, 1'b0};
   endfunction

   function automatic cwork_t f_set_rx(cwork_t w);
      cwork_t r;
      r        = w;
      r.st.rxp = 1'b1;
      r.st.rxs = 1'b1;
      r.st.rxb = 1'b1;
      r.wr     = 1'b1;
      r.kind   = VK_RX;
      return r;
   endfunction

   function automatic cwork_t f_set_tx(cwork_t w, logic txie);
      cwork_t r;
      r        = w;
      r.st.txp = 1'b1;
      if (!r.st.rxs) begin
         r.st.txs = 1'b1;
         if (txie) r.st.txb = 1'b1;
         r.wr     = 1'b1;
         r.kind   = VK_TX;
      end
      return r;
   endfunction

   function automatic cwork_t f_clr_rx(cwork_t w, logic txie);
      cwork_t r;
      r        = w;
      r.st.rxp = 1'b0;
      r.st.rxs = 1'b0;
      r.st.rxb = 1'b0;
      r.wr     = 1'b1;
      r.kind   = VK_NONE;
      if (r.st.txp) r = f_set_tx(r, txie);
      return r;
   endfunction

   function automatic cwork_t f_clr_tx(cwork_t w);
      cwork_t r;
      r        = w;
      r.st.txp = 1'b0;
      r.st.txs = 1'b0;
      r.st.txb = 1'b0;
      r.wr     = 1'b1;
      r.kind   = VK_NONE;
      if (r.st.rxp) r = f_set_rx(r);
      return r;
   endfunction

   function automatic cwork_t f_rst_ius(cwork_t w, logic txie);
      cwork_t r;
      r = w;
      if (r.st.rxs) begin
         r.st.rxs = 1'b0;
         if (r.st.txp) r = f_set_tx(r, txie);
      end else if (r.st.txs) begin
         r.st.txs = 1'b0;
      end
      return r;
   endfunction

endpackage

// File: rtl/sivec_chan.sv
module sivec_chan
   import sivec_pkg::*;
#(
   parameter int CH_IDX = 0,
   parameter int VEC_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_char_i,
   input  logic             tx_load_i,
   input  logic             rd_data_i,
   input  logic             clr_tx_i,
   input  logic             rst_ius_i,
   input  logic             brk_det_i,
   input  logic             tx_ie_i,
   input  logic [1:0]       rx_mode_i,
   input  logic             brk_ie_i,
   input  logic             status_hi_i,
   output logic             rx_pbit_o,
   output logic             tx_pbit_o,
   output logic             vec_wr_o,
   output logic [VEC_W-1:0] vec_val_o,
   output logic             req_o
);

   localparam logic IS_B = (CH_IDX != 0);

   chst_t  st_q;
   logic   brk_q;
   cwork_t work;
   logic   rx_mode_on;

   // apply this cycle's events in their fixed order
   always_comb begin
      work.st   = st_q;
      work.wr   = 1'b0;
      work.kind = VK_NONE;
      if (rd_data_i) work = f_clr_rx(work, tx_ie_i);
      if (clr_tx_i)  work = f_clr_tx(work);
      if (rst_ius_i) work = f_rst_ius(work, tx_ie_i);
      if (rx_char_i) work = f_set_rx(work);
      if (tx_load_i) work = f_set_tx(work, tx_ie_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         brk_q <= 1'b0;
      end else begin
         st_q <= work.st;
         if (brk_det_i) brk_q <= 1'b1;
      end
   end

   assign rx_mode_on = (rx_mode_i == 2'b01) || (rx_mode_i == 2'b10);

   assign req_o     = (tx_ie_i && st_q.txp) ||
                      (rx_mode_on && st_q.rxp) ||
                      (brk_ie_i && brk_q);
   assign rx_pbit_o = st_q.rxb;
   assign tx_pbit_o = st_q.txb;
   assign vec_wr_o  = work.wr;
   assign vec_val_o = VEC_W'(vec_value(work.kind, IS_B, status_hi_i));

endmodule

// File: rtl/sivec_vec_reg.sv
module sivec_vec_reg #(
   parameter int NUM_CH = 2,
   parameter int VEC_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       wr_i,
   input  logic [NUM_CH*VEC_W-1:0] val_i,
   output logic [VEC_W-1:0]        vec_o
);

   logic [VEC_W-1:0] vec_q;
   logic [VEC_W-1:0] vec_d;

   // higher channel index is applied later and wins
   always_comb begin
      vec_d = vec_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (wr_i[i]) vec_d = val_i[i*VEC_W +: VEC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else        vec_q <= vec_d;
   end

   assign vec_o = vec_q;

endmodule

// File: rtl/sivec_irq_out.sv
module sivec_irq_out #(
   parameter int NUM_CH     = 2,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   output logic              irq_o
);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |req_i;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = |req_i;
   end

endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
   import sivec_pkg::*;
#(
   parameter int NUM_CH         = 2,
   parameter int PEND_W         = 8,
   parameter int VEC_W          = 8,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   rx_char_i,
   input  logic [NUM_CH-1:0]   tx_load_i,
   input  logic [NUM_CH-1:0]   rd_data_i,
   input  logic [NUM_CH-1:0]   clr_tx_i,
   input  logic [NUM_CH-1:0]   rst_ius_i,
   input  logic [NUM_CH-1:0]   brk_det_i,
   input  logic [NUM_CH-1:0]   tx_ie_i,
   input  logic [2*NUM_CH-1:0] rx_mode_i,
   input  logic [NUM_CH-1:0]   brk_ie_i,
   input  logic                status_hi_i,
   output logic                irq_o,
   output logic [PEND_W-1:0]   pend_o,
   output logic [VEC_W-1:0]    vec_o
);

   localparam int VBUS_W = NUM_CH * VEC_W;

   // elaboration-time parameter checks
   if (NUM_CH != 2) begin : g_bad_nch
      $error("sio_irq_vector: NUM_CH must be 2");
   end
   if (PEND_W < 6) begin : g_bad_pend
      $error("sio_irq_vector: PEND_W must be at least 6");
   end
   if (VEC_W < 7) begin : g_bad_vec
      $error("sio_irq_vector: VEC_W must be at least 7");
   end

   logic [NUM_CH-1:0] rx_pbit;
   logic [NUM_CH-1:0] tx_pbit;
   logic [NUM_CH-1:0] vec_wr;
   logic [NUM_CH-1:0] req;
   logic [VBUS_W-1:0] vec_bus;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sivec_chan #(
         .CH_IDX (c),
         .VEC_W  (VEC_W)
      ) chan_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .rx_char_i   (rx_char_i[c]),
         .tx_load_i   (tx_load_i[c]),
         .rd_data_i   (rd_data_i[c]),
         .clr_tx_i    (clr_tx_i[c]),
         .rst_ius_i   (rst_ius_i[c]),
         .brk_det_i   (brk_det_i[c]),
         .tx_ie_i     (tx_ie_i[c]),
         .rx_mode_i   (rx_mode_i[2*c +: 2]),
         .brk_ie_i    (brk_ie_i[c]),
         .status_hi_i (status_hi_i),
         .rx_pbit_o   (rx_pbit[c]),
         .tx_pbit_o   (tx_pbit[c]),
         .vec_wr_o    (vec_wr[c]),
         .vec_val_o   (vec_bus[c*VEC_W +: VEC_W]),
         .req_o       (req[c])
      );
   end

   sivec_vec_reg #(
      .NUM_CH (NUM_CH),
      .VEC_W  (VEC_W)
   ) vreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (vec_wr),
      .val_i (vec_bus),
      .vec_o (vec_o)
   );

   sivec_irq_out #(
      .NUM_CH     (NUM_CH),
      .REGISTERED (IRQ_REGISTERED)
   ) irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req),
      .irq_o (irq_o)
   );

   // place the per-channel flops into the pending register
   always_comb begin
      pend_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         pend_o[rx_pend_pos(c)] = rx_pbit[c];
         pend_o[tx_pend_pos(c)] = tx_pbit[c];
      end
   end

endmodule

// File: rtl/sivec_chk.sv
module sivec_chk #(
   parameter int PEND_W = 8,
   parameter int VEC_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        rx_char_i,
   input logic [1:0]        tx_load_i,
   input logic [1:0]        rd_data_i,
   input logic [1:0]        clr_tx_i,
   input logic [1:0]        rst_ius_i,
   input logic              status_hi_i,
   input logic [PEND_W-1:0] pend_o,
   input logic [VEC_W-1:0]  vec_o
);

   // R2: received character on A sets pending bit 5 on that edge
   a_r2_rx_sets_pend_a: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_i[0] |=> pend_o[5]);

   // R2 / R10: B is applied last, so its receive code lands in the vector
   a_r2_rx_vec_b: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_i[1] |=> (vec_o == ($past(status_hi_i) ? VEC_W'(8'h20) : VEC_W'(8'h04))));

   // R6: a read without a new character clears the A receive bit
   a_r6_read_clears_rx_a: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_i[0] && !rx_char_i[0]) |=> !pend_o[5]);

   // R8: clear-transmit drops the B transmit bit unless a new load follows
   a_r8_clrtx_clears_b: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tx_i[1] && !tx_load_i[1]) |=> !pend_o[1]);

   // R5: a load in the same cycle as a receive is held back from service
   a_r5_tx_blocked_b: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load_i[1] && rx_char_i[1] && !rd_data_i[1] && !rst_ius_i[1] && !pend_o[1])
      |=> !pend_o[1]);

endmodule

bind sio_irq_vector sivec_chk #(
   .PEND_W (PEND_W),
   .VEC_W  (VEC_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_char_i   (rx_char_i),
   .tx_load_i   (tx_load_i),
   .rd_data_i   (rd_data_i),
   .clr_tx_i    (clr_tx_i),
   .rst_ius_i   (rst_ius_i),
   .status_hi_i (status_hi_i),
   .pend_o      (pend_o),
   .vec_o       (vec_o)
);

// File: tb/sio_irq_vector_tb_top.sv
`timescale 1ns/1ps
module sio_irq_vector_tb_top;

   typedef struct packed {
      logic [1:0] rd;
      logic [1:0] clr;
      logic [1:0] ius;
      logic [1:0] rx;
      logic [1:0] tx;
      logic [1:0] brk;
      logic [1:0] txie;
      logic [1:0] ma;
      logic [1:0] mb;
      logic [1:0] bie;
      logic       hi;
      logic [7:0] pend;
      logic [7:0] vec;
      logic       irq;
      logic [3:0] req;
   } step_t;

   localparam int NSTEP = 42;

   // rd clr ius rx tx brk | txie ma mb bie hi | pend vec irq req
   localparam step_t STEPS [NSTEP] = '{
      '{2'b00,2'b00,2'b00,2'b01,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h20,8'h0C,1'b1,4'd2},  // R2 rx A
      '{2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h20,8'h0C,1'b1,4'd5},  // R5 tx A blocked
      '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h10,8'h08,1'b1,4'd6},  // R6 read promotes tx
      '{2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd8},  // R8
      '{2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h04,8'h04,1'b1,4'd2},  // R2 rx B
      '{2'b10,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd6},  // R6
      '{2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 2'b11,2'b01,2'b11,2'b00,1'b0, 8'h04,8'h04,1'b0,4'd3},  // R3 mode 11
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b00,2'b00,1'b0, 8'h04,8'h04,1'b0,4'd3},  // R3 mode 00
      '{2'b10,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b00,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd6},  // R6
      '{2'b00,2'b00,2'b00,2'b00,2'b10,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h02,8'h00,1'b1,4'd4},  // R4 tx B
      '{2'b00,2'b00,2'b10,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h02,8'h00,1'b1,4'd7},  // R7 tx-ius only
      '{2'b00,2'b10,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd8},  // R8
      '{2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 2'b00,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h08,1'b0,4'd4},  // R4 enable off
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h08,1'b1,4'd4},  // R4 enable on
      '{2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd8},  // R8
      '{2'b00,2'b00,2'b00,2'b01,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h20,8'h0C,1'b1,4'd2},  // R2
      '{2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h20,8'h0C,1'b1,4'd5},  // R5
      '{2'b00,2'b00,2'b01,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h30,8'h08,1'b1,4'd7},  // R7 promotion
      '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h10,8'h08,1'b1,4'd6},  // R6
      '{2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd8},  // R8
      '{2'b00,2'b00,2'b00,2'b01,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h20,8'h30,1'b1,4'd10}, // R10
      '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h00,8'h60,1'b0,4'd10}, // R10
      '{2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h04,8'h20,1'b1,4'd10}, // R10
      '{2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h14,8'h10,1'b1,4'd10}, // R10
      '{2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h04,8'h60,1'b1,4'd10}, // R10
      '{2'b00,2'b00,2'b00,2'b00,2'b10,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h04,8'h60,1'b1,4'd5},  // R5
      '{2'b10,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h02,8'h00,1'b1,4'd10}, // R10
      '{2'b00,2'b10,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b1, 8'h00,8'h60,1'b0,4'd8},  // R8
      '{2'b00,2'b00,2'b00,2'b11,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h24,8'h04,1'b1,4'd11}, // R11 B wins
      '{2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd11}, // R11
      '{2'b01,2'b00,2'b00,2'b01,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h20,8'h0C,1'b1,4'd11}, // R11 read then rx
      '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd6},  // R6
      '{2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h04,8'h04,1'b1,4'd2},  // R2
      '{2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h14,8'h08,1'b1,4'd4},  // R4
      '{2'b00,2'b10,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h14,8'h04,1'b1,4'd8},  // R8 rx re-set
      '{2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h04,8'h06,1'b1,4'd8},  // R8
      '{2'b10,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd6},  // R6
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b01, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd9},  // R9 disabled
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b01,1'b0, 8'h00,8'h06,1'b1,4'd9},  // R9 sticky
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd9},  // R9
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b11,2'b01,2'b10,2'b10,1'b0, 8'h00,8'h06,1'b1,4'd9},  // R9 B
      '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b11,2'b01,2'b10,2'b00,1'b0, 8'h00,8'h06,1'b0,4'd9}   // R9
   };

   logic       clk;
   logic       rst_n;
   logic [1:0] rx_char, tx_load, rd_data, clr_tx, rst_ius, brk_det;
   logic [1:0] tx_ie, brk_ie;
   logic [3:0] rx_mode;
   logic       status_hi;
   logic       irq;
   logic [7:0] pend;
   logic [7:0] vec;

   int n_chk;
   int n_bad;
   bit done;

   sio_irq_vector dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_char_i   (rx_char),
      .tx_load_i   (tx_load),
      .rd_data_i   (rd_data),
      .clr_tx_i    (clr_tx),
      .rst_ius_i   (rst_ius),
      .brk_det_i   (brk_det),
      .tx_ie_i     (tx_ie),
      .rx_mode_i   (rx_mode),
      .brk_ie_i    (brk_ie),
      .status_hi_i (status_hi),
      .irq_o       (irq),
      .pend_o      (pend),
      .vec_o       (vec)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic check(input logic [7:0] got, input logic [7:0] exp,
                        input int req, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %02h expected %02h (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   task automatic clear_events();
      rx_char = '0; tx_load = '0; rd_data = '0;
      clr_tx  = '0; rst_ius = '0; brk_det = '0;
   endtask

   task automatic run_step(input step_t s);
      @(negedge clk);
      rd_data = s.rd; clr_tx = s.clr; rst_ius = s.ius;
      rx_char = s.rx; tx_load = s.tx; brk_det = s.brk;
      tx_ie = s.txie; rx_mode = {s.mb, s.ma}; brk_ie = s.bie; status_hi = s.hi;
      @(negedge clk);
      clear_events();
      @(negedge clk);
      check(pend, s.pend, int'(s.req), "pending");
      check(vec, s.vec, int'(s.req), "vector");
      check({7'd0, irq}, {7'd0, s.irq}, int'(s.req), "irq");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      n_chk = 0; n_bad = 0; done = 1'b0;
      clear_events();
      tx_ie = 2'b11; rx_mode = 4'b1001; brk_ie = 2'b00; status_hi = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pend, 8'h00, 1, "reset pending");
      check(vec, 8'h00, 1, "reset vector");
      check({7'd0, irq}, 8'h00, 1, "reset irq");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NSTEP; i++) run_step(STEPS[i]);

      // R3: request lags the pending flag by one edge
      @(negedge clk);
      rx_char = 2'b01;
      @(negedge clk);
      clear_events();
      check(pend, 8'h20, 2, "pending same edge");
      check({7'd0, irq}, 8'h00, 3, "irq before lag edge");
      @(negedge clk);
      check({7'd0, irq}, 8'h01, 3, "irq after lag edge");

      // R1 and R9: mid-run reset clears flags and sticky breaks
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(pend, 8'h00, 1, "mid reset pending");
      check(vec, 8'h00, 1, "mid reset vector");
      check({7'd0, irq}, 8'h00, 1, "mid reset irq");
      rst_n = 1'b1;
      brk_ie = 2'b11;
      repeat (2) @(negedge clk);
      check({7'd0, irq}, 8'h00, 9, "break cleared by reset");

      finish_run();
   end

endmodule